// File: doc/BRIEF.md
# E1 Time-Slot-Zero Framing Receiver

This block takes a 2048 kbit/s serial stream of 256-bit, 32-slot frames, together with a one-cycle bit strobe. It finds the time-slot-zero framing and then tracks it. Time slot zero carries two kinds of word in turn. In alignment frames it holds the alignment pattern `x0011011`, where the first bit is free. In the frames between, it holds a non-alignment word whose second bit is 1. Acquisition uses three steps: a pattern match, a correct second bit one frame later, and a correct pattern one frame after that. Lock is dropped when three alignment words in a row are corrupted.

The framing decision drives four outputs. A time-slot-zero marker can feed a downstream frame aligner. An active-low channel reset pulse serves other receive blocks. A loss-of-alignment alarm reports the lock state. A word-error flag, reported with a fixed two-frame latency, is the basis for AIS generation. The spare bits of both time-slot-zero words are also presented as parallel outputs.

Bit positions inside a frame are numbered 0 to 255 in order of arrival. Time slot zero occupies positions 0 to 7, and its bit 1 is position 0. Time slot 1, bit 2 is position 9. All state advances only on a clock edge where `bit_en` is high.

Top module: `e1_ts0_sync`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, sets `sync_alarm` to 1, `word_err` to 0, `fas_spare` to 0 and `nfas_spare` to 0. It also sets the frame position to 0, so `ts0_mark` is 1 and `chan_rst_n` is 1.
- R2: While searching, the block tests the last eight received bits at every bit for a match: bits 2..8 must equal 0011011. A match fixes the frame position so that the matching bit is position 7 of an alignment frame. Lock is declared when two further conditions hold. Bit 2 of the word at position 7 one frame later must be 1. The pattern at position 7 one frame after that must match. `sync_alarm` falls at the edge that takes in that last bit.
- R3: If either confirmation step fails, the block returns to the bit-by-bit search starting with the next bit, and `sync_alarm` stays 1.
- R4: While locked, every alignment word is checked. Three checked words in a row that do not match raise `sync_alarm` at the edge that takes in the third. One or two bad words in a row, followed by a good word, leave lock unchanged.
- R5: `ts0_mark` is 1 during the bit periods of positions 0 to 7. While not locked, the frame counter free-runs from the last position it was given.
- R6: `chan_rst_n` is 0 during the bit period of position 8. This happens in every frame while not locked, and only in alignment frames while locked.
- R7: While locked, `word_err` changes only at the edge that starts position 9 of an alignment frame. At that edge it takes the check result of the alignment word received two frames earlier: 1 for bad, 0 for good.
- R8: While not locked, `word_err` is 1 at every bit. The exception is position 9 of the frame two frames after the most recent correct alignment word, where it is 0 for one bit period. A correct word counts here whether it came from a search match, from the final acquisition step, or from a check while locked.
- R9: At the edge that restores lock, `word_err` goes to 0. Reporting then starts again from the word that restored lock, so the flag stays 0 for at least the next two frames.
- R10: While locked, two captures happen at position 7. In an alignment frame, `fas_spare` takes bit 1 of the word. In a non-alignment frame, `nfas_spare` takes bits {1,3,4,5,6,7,8} with bit 1 as the MSB.
- R11: A clock edge with `bit_en` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit strobe; one remote bit per high cycle |
| rx_data | input | 1 | Remote serial data, sampled when `bit_en` is high |
| ts0_mark | output | 1 | High during time slot zero of the tracked frame |
| chan_rst_n | output | 1 | Active-low channel reset pulse |
| sync_alarm | output | 1 | Loss-of-alignment alarm, high when not locked |
| word_err | output | 1 | Alignment word error flag, two frames late |
| fas_spare | output | 1 | Bit 1 of the latest alignment word |
| nfas_spare | output | 7 | Bits 1,3..8 of the latest non-alignment word |

## Verification
Suppose the frame counter slips by even one bit. `ts0_mark` and `chan_rst_n` then move at the next frame boundary, and the next alignment check fails, so `word_err` rises within two frames. A wrong search or confirmation state shows as `sync_alarm` falling in the wrong frame or not falling at all. An error history that is stale or out of order shows up at the first report point after the fault. The stream injects single, double and triple errors and a bad non-alignment bit during acquisition. It also uses a bit strobe with random gaps, so every output is compared at every bit period against a model of the rules above.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;

    // Framing state of the receiver
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,   // bit-by-bit pattern search
        ST_CHK_NFAS = 2'd1,   // waiting for the second-bit check one frame on
        ST_CHK_FAS  = 2'd2,   // waiting for the confirming pattern
        ST_LOCKED   = 2'd3    // frame alignment held
    } fr_state_t;

endpackage

// File: rtl/ts0_shifter.sv
module ts0_shifter #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 din,
    output logic [WORD_BITS-1:0] word_now
);
    localparam int HW = WORD_BITS - 1;

    logic [HW-1:0] hist_d, hist_q;

    // the most recent WORD_BITS bits, including the one being sampled now
    assign word_now = {hist_q, din};

    always_comb begin
        hist_d = hist_q;
        if (bit_en) begin
            hist_d = word_now[HW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

endmodule

// File: rtl/ts0_slot_ctr.sv
module ts0_slot_ctr #(
    parameter int FRAME_BITS = 256,
    parameter int WORD_BITS  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic realign,
    output logic in_ts0,
    output logic word_end,
    output logic post_word,
    output logic frame_end,
    output logic ph_fas
);
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] WEND_POS = CW'(WORD_BITS - 1);
    localparam logic [CW-1:0] POST_POS = CW'(WORD_BITS);

    typedef struct packed {
        logic [CW-1:0] pos;
        logic          fas;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    assign in_ts0    = (ctr_q.pos < POST_POS);
    assign word_end  = (ctr_q.pos == WEND_POS);
    assign post_word = (ctr_q.pos == POST_POS);
    assign frame_end = (ctr_q.pos == LAST_POS);
    assign ph_fas    = ctr_q.fas;

    always_comb begin
        ctr_d = ctr_q;
        if (bit_en) begin
            if (realign) begin
                // the bit just taken is position WORD_BITS-1 of an alignment frame
                ctr_d.pos = POST_POS;
                ctr_d.fas = 1'b1;
            end else if (frame_end) begin
                ctr_d.pos = '0;
                ctr_d.fas = ~ctr_q.fas;
            end else begin
                ctr_d.pos = ctr_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '{pos: '0, fas: 1'b1};
        end else begin
            ctr_q <= ctr_d;
        end
    end

endmodule

// File: rtl/ts0_err_report.sv
module ts0_err_report (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic locked,
    input  logic regain,
    input  logic fas_chk,
    input  logic fas_bad,
    input  logic report_pt,
    input  logic drop_pt,
    output logic word_err
);
    typedef struct packed {
        logic [1:0] hist;   // [1] = result two alignment frames back
        logic       flag;
    } rep_t;

    rep_t rep_d, rep_q;

    assign word_err = rep_q.flag;

    always_comb begin
        rep_d = rep_q;
        if (bit_en) begin
            if (regain) begin
                rep_d.hist = 2'b00;
                rep_d.flag = 1'b0;
            end else if (locked) begin
                if (fas_chk) begin
                    rep_d.hist = {rep_q.hist[0], fas_bad};
                end
                if (report_pt) begin
                    rep_d.flag = rep_q.hist[1];
                end
            end else begin
                rep_d.flag = ~drop_pt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q <= '{hist: 2'b00, flag: 1'b0};
        end else begin
            rep_q <= rep_d;
        end
    end

endmodule

// File: rtl/e1_ts0_sync.sv
module e1_ts0_sync
    import e1ts0_pkg::*;
#(
    parameter int                 FRAME_BITS  = 256,
    parameter int                 WORD_BITS   = 8,
    parameter int                 LOSS_LIMIT  = 3,
    parameter logic [WORD_BITS-2:0] FAS_PATTERN = 7'b0011011
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 rx_data,
    output logic                 ts0_mark,
    output logic                 chan_rst_n,
    output logic                 sync_alarm,
    output logic                 word_err,
    output logic                 fas_spare,
    output logic [WORD_BITS-2:0] nfas_spare
);
    localparam int EW = (LOSS_LIMIT > 2) ? $clog2(LOSS_LIMIT) : 1;
    localparam logic [EW-1:0] ERR_LAST = EW'(LOSS_LIMIT - 1);
    localparam int SW = WORD_BITS - 1;

    typedef struct packed {
        fr_state_t     st;
        logic [EW-1:0] errc;
        logic [1:0]    fsince;   // frames since last correct word, saturating
        logic          fas_sp;
        logic [SW-1:0] nfas_sp;
    } core_t;

    core_t core_d, core_q;

    logic [WORD_BITS-1:0] word_now;
    logic in_ts0, word_end, post_word, frame_end, ph_fas;
    logic realign, regain, fas_chk;
    logic fas_ok, nfas_ok, locked;

    ts0_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .din      (rx_data),
        .word_now (word_now)
    );

    ts0_slot_ctr #(.FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .realign   (realign),
        .in_ts0    (in_ts0),
        .word_end  (word_end),
        .post_word (post_word),
        .frame_end (frame_end),
        .ph_fas    (ph_fas)
    );

    ts0_err_report u_rep (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .locked    (locked),
        .regain    (regain),
        .fas_chk   (fas_chk),
        .fas_bad   (~fas_ok),
        .report_pt (post_word & ph_fas),
        .drop_pt   (post_word & (core_q.fsince == 2'd2)),
        .word_err  (word_err)
    );

    assign fas_ok  = (word_now[SW-1:0] == FAS_PATTERN);
    assign nfas_ok = word_now[SW-1];
    assign locked  = (core_q.st == ST_LOCKED);

    always_comb begin
        core_d  = core_q;
        realign = 1'b0;
        regain  = 1'b0;
        fas_chk = 1'b0;
        if (bit_en) begin
            if (frame_end && core_q.fsince != 2'd3) begin
                core_d.fsince = core_q.fsince + 2'd1;
            end
            unique case (core_q.st)
                ST_HUNT: begin
                    if (fas_ok) begin
                        core_d.st     = ST_CHK_NFAS;
                        core_d.fsince = 2'd0;
                        realign       = 1'b1;
                    end
                end
                ST_CHK_NFAS: begin
                    if (word_end && !ph_fas) begin
                        core_d.st = nfas_ok ? ST_CHK_FAS : ST_HUNT;
                    end
                end
                ST_CHK_FAS: begin
                    if (word_end && ph_fas) begin
                        if (fas_ok) begin
                            core_d.st     = ST_LOCKED;
                            core_d.errc   = '0;
                            core_d.fsince = 2'd0;
                            regain        = 1'b1;
                        end else begin
                            core_d.st = ST_HUNT;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (word_end) begin
                        if (ph_fas) begin
                            fas_chk       = 1'b1;
                            core_d.fas_sp = word_now[WORD_BITS-1];
                            if (fas_ok) begin
                                core_d.errc   = '0;
                                core_d.fsince = 2'd0;
                            end else if (core_q.errc == ERR_LAST) begin
                                core_d.errc = '0;
                                core_d.st   = ST_HUNT;
                            end else begin
                                core_d.errc = core_q.errc + 1'b1;
                            end
                        end else begin
                            core_d.nfas_sp = {word_now[WORD_BITS-1], word_now[SW-2:0]};
                        end
                    end
                end
                default: core_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '{st: ST_HUNT, errc: '0, fsince: 2'd3, fas_sp: 1'b0, nfas_sp: '0};
        end else begin
            core_q <= core_d;
        end
    end

    assign ts0_mark   = in_ts0;
    assign chan_rst_n = ~(post_word & (~locked | ph_fas));
    assign sync_alarm = ~locked;
    assign fas_spare  = core_q.fas_sp;
    assign nfas_spare = core_q.nfas_sp;

endmodule

// File: rtl/e1_ts0_sync_chk.sv
module e1_ts0_sync_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic ts0_mark,
    input logic chan_rst_n,
    input logic sync_alarm,
    input logic word_err,
    input logic fas_spare
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (sync_alarm && !word_err && !fas_spare && ts0_mark && chan_rst_n));

    p_lock_on_bit_r2: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $fell(sync_alarm) |-> $past(bit_en));

    p_loss_on_bit_r4: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $rose(sync_alarm) |-> $past(bit_en));

    p_reset_after_ts0_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !chan_rst_n |-> !ts0_mark);

    p_regain_clear_r9: assert property (@(posedge clk) disable iff (rst || !armed_q)
        $fell(sync_alarm) |-> !word_err);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$past(bit_en) |-> ($stable(word_err) && $stable(sync_alarm) && $stable(ts0_mark)
                            && $stable(chan_rst_n) && $stable(fas_spare)));

endmodule

bind e1_ts0_sync e1_ts0_sync_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .ts0_mark   (ts0_mark),
    .chan_rst_n (chan_rst_n),
    .sync_alarm (sync_alarm),
    .word_err   (word_err),
    .fas_spare  (fas_spare)
);

// File: tb/e1_ts0_sync_test.sv
module e1_ts0_sync_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic rx_data = 1'b0;
    logic ts0_mark, chan_rst_n, sync_alarm, word_err, fas_spare;
    logic [6:0] nfas_spare;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    e1_ts0_sync uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_data(rx_data),
        .ts0_mark(ts0_mark), .chan_rst_n(chan_rst_n), .sync_alarm(sync_alarm),
        .word_err(word_err), .fas_spare(fas_spare), .nfas_spare(nfas_spare)
    );

    // reference state, kept from the requirement text
    int m_st;          // 0 search, 1 second-bit wait, 2 pattern wait, 3 locked
    int m_pos;
    bit m_afr;         // current frame is an alignment frame
    bit [6:0] m_sr;
    int m_fs;
    int m_bad_run;
    bit [1:0] m_hist;
    bit m_flag;
    bit m_fsp;
    bit [6:0] m_nsp;
    bit pend_r9, pend_r3;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit bad_fas_frame(input int f);
        return f inside {10, 20, 22, 30, 32, 34, 60, 62, 64, 68, 76};
    endfunction

    function automatic bit bad_nfas_frame(input int f);
        return f inside {37};
    endfunction

    function automatic bit gen_bit(input int g);
        int f = g / 256;
        int b = g % 256;
        bit [7:0] pat = 8'b00011011;
        if (b < 8 && (f % 2) == 0 && b != 0) begin
            return (b == 4 && bad_fas_frame(f)) ? ~pat[7-b] : pat[7-b];
        end
        if (b == 1 && (f % 2) == 1) return ~bad_nfas_frame(f);
        return 1'($urandom % 2);
    endfunction

    task automatic m_step(input bit d);
        bit [7:0] w = {m_sr, d};
        bit good = (w[6:0] == 7'b0011011);
        bit was_locked = (m_st == 3);
        bit rg = 0, ck = 0, ra = 0;
        bit drop = (m_pos == 8) && (m_fs == 2);
        if (m_pos == 255 && m_fs < 3) m_fs++;
        case (m_st)
            0: if (good) begin m_st = 1; m_fs = 0; ra = 1; end
            1: if (m_pos == 7 && !m_afr) begin
                   if (w[6]) m_st = 2; else begin m_st = 0; pend_r3 = 1; end
               end
            2: if (m_pos == 7 && m_afr) begin
                   if (good) begin m_st = 3; m_bad_run = 0; m_fs = 0; rg = 1; end
                   else begin m_st = 0; pend_r3 = 1; end
               end
            default: if (m_pos == 7) begin
                   if (m_afr) begin
                       ck = 1; m_fsp = w[7];
                       if (good) begin m_bad_run = 0; m_fs = 0; end
                       else if (m_bad_run == 2) begin m_bad_run = 0; m_st = 0; end
                       else m_bad_run++;
                   end else m_nsp = {w[7], w[5:0]};
               end
        endcase
        if (rg) begin m_hist = 0; m_flag = 0; pend_r9 = 1; end
        else if (was_locked) begin
            if (m_pos == 8 && m_afr) m_flag = m_hist[1];
            if (ck) m_hist = {m_hist[0], ~good};
        end else m_flag = ~drop;
        if (ra) begin m_pos = 8; m_afr = 1; end
        else if (m_pos == 255) begin m_pos = 0; m_afr = ~m_afr; end
        else m_pos++;
        m_sr = w[6:0];
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int g;
        bit last_en;
        logic [4:0] prev;
        void'($urandom(32'd4242));
        m_st = 0; m_pos = 0; m_afr = 1; m_sr = 0; m_fs = 3; m_bad_run = 0;
        m_hist = 0; m_flag = 0; m_fsp = 0; m_nsp = 0; pend_r9 = 0; pend_r3 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(sync_alarm == 1'b1, "R1 alarm", int'(sync_alarm), 1);
        chk(word_err == 1'b0, "R1 flag", int'(word_err), 0);
        chk(fas_spare == 1'b0 && nfas_spare == 7'd0, "R1 spares", int'({fas_spare, nfas_spare}), 0);
        chk(ts0_mark == 1'b1 && chan_rst_n == 1'b1, "R1 marks", int'({ts0_mark, chan_rst_n}), 3);
        g = 37;
        last_en = 1'b0;
        prev = {ts0_mark, chan_rst_n, sync_alarm, word_err, fas_spare};
        while (g < 100 * 256) begin
            @(negedge clk);
            if (!last_en) begin
                chk({ts0_mark, chan_rst_n, sync_alarm, word_err, fas_spare} == prev,
                    "R11 idle edge", int'({ts0_mark, chan_rst_n, sync_alarm, word_err, fas_spare}), int'(prev));
            end
            chk(ts0_mark == (m_pos < 8), "R5 ts0_mark", int'(ts0_mark), int'(m_pos < 8));
            chk(chan_rst_n == !(m_pos == 8 && (m_st != 3 || m_afr)), "R6 chan_rst_n",
                int'(chan_rst_n), int'(!(m_pos == 8 && (m_st != 3 || m_afr))));
            chk(sync_alarm == (m_st != 3), (m_st == 3) ? "R2 alarm" : "R4 alarm",
                int'(sync_alarm), int'(m_st != 3));
            chk(word_err == m_flag, (m_st == 3) ? "R7 word_err" : "R8 word_err",
                int'(word_err), int'(m_flag));
            chk(fas_spare == m_fsp && nfas_spare == m_nsp, "R10 spares",
                int'({fas_spare, nfas_spare}), int'({m_fsp, m_nsp}));
            if (pend_r9) begin
                chk(word_err == 1'b0 && sync_alarm == 1'b0, "R9 regain", int'({sync_alarm, word_err}), 0);
                pend_r9 = 0;
            end
            if (pend_r3) begin
                chk(sync_alarm == 1'b1, "R3 step fail", int'(sync_alarm), 1);
                pend_r3 = 0;
            end
            prev = {ts0_mark, chan_rst_n, sync_alarm, word_err, fas_spare};
            last_en = (($urandom % 4) != 0);
            bit_en = last_en;
            if (last_en) begin
                rx_data = gen_bit(g);
                m_step(rx_data);
                g++;
            end else begin
                rx_data = 1'($urandom % 2);
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule